// File: doc/BRIEF.md
# Flash Write-Strobe Qualifier

This block stands between the host-facing strobe pins of a flash macro and its command engine. It decides whether a write-enable pulse is a real write. Chip-enable, output-enable, write-enable, the host reset pin and a supply-good bit arrive asynchronously. Each one is resynchronized before any decision is made. The block then rejects write pulses that are too short, applies the static conditions that inhibit a write, and refuses all writes during a lockout window after the supply comes up. The command engine receives two single-cycle events from it: one that marks where the address should be captured and one that commits the write.

Two state machines share the work. The mode machine tracks supply and reset. Its states are OFF (supply not good), ACTIVE, QUAL (reset pin low, duration not yet qualified), HALT and RECOV (reset released, reads still held off). Its transitions are:

- OFF→ACTIVE, or OFF→HALT if the pin is low.
- ACTIVE→QUAL on a low pin.
- QUAL→ACTIVE on a short pulse.
- QUAL→HALT once the minimum low time is reached.
- HALT→RECOV on release.
- RECOV→HALT on a new low.
- RECOV→ACTIVE after the recovery count.
- Any state→OFF when the supply is lost.

The strobe machine has the states IDLE, COUNT (strobe low, width being measured), ARMED (width met) and BLOCKED (wait for the strobe to return high). Its transitions are:

- IDLE→COUNT, or IDLE→ARMED when one cycle is enough, on a permitted falling edge.
- IDLE→BLOCKED on a falling edge that is not permitted.
- COUNT→IDLE on an early rise.
- COUNT→ARMED when the width is met.
- COUNT/ARMED→BLOCKED when permission is withdrawn.
- ARMED→IDLE on the rise, which emits the commit.
- BLOCKED→IDLE on the rise.

Every duration is given in time units and converted to cycles from the clock-period parameter, rounding up.

Top module: `wr_qualifier`

## Requirements
- R1: While `arst_n` is low, `wr_start`, `wr_commit` and `halt_pulse` are 0, `out_hiz` is 1 and `rd_en` is 0.
- R2: While the synchronized `pwr_ok` is 0, `rd_en` is 0, `out_hiz` is 1, and no `wr_start` or `wr_commit` pulse is produced.
- R3: After `pwr_ok` rises, reads are enabled within a few cycles. Writes stay blocked for LOCKOUT_NS converted to cycles, and a write attempted in that window yields neither `wr_start` nor `wr_commit`.
- R4: A falling edge of `we_n` is permitted only while `ce_n`=0, `oe_n`=1 and writes are allowed. It yields exactly one single-cycle `wr_start`.
- R5: When a permitted low of `we_n` lasts at least MIN_WE_CYC = ceil(MIN_WE_PS/CLK_PERIOD_PS) cycles, its rising edge yields exactly one single-cycle `wr_commit`.
- R6: A permitted low of `we_n` shorter than MIN_WE_CYC cycles yields a `wr_start` but no `wr_commit`.
- R7: If `ce_n`=1 or `oe_n`=0 at the falling edge, neither pulse occurs. If either condition appears while the strobe is low, no commit occurs. A strobe that is already low when the inhibit clears does not start a write until it has gone high again.
- R8: A low on `rpin_n` lasting at least RST_MIN_CYC cycles yields one single-cycle `halt_pulse` and drives `out_hiz`=1 and `rd_en`=0. Writes are blocked while the pin stays low.
- R9: A low on `rpin_n` shorter than RST_MIN_CYC cycles is ignored: no `halt_pulse`, and `out_hiz` stays 0.
- R10: After `rpin_n` is released from a halt, `rd_en` and writes stay off for RECOV_CYC cycles plus synchronization latency, then return.
- R11: Losing the supply produces one `halt_pulse`. When the supply returns, the write lockout of R3 starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| ce_n | input | 1 | Host chip-enable, active low, asynchronous |
| oe_n | input | 1 | Host output-enable, active low, asynchronous |
| we_n | input | 1 | Host write-enable, active low, asynchronous |
| rpin_n | input | 1 | Host reset pin, active low, asynchronous |
| pwr_ok | input | 1 | Supply above sense level, asynchronous |
| wr_start | output | 1 | Single-cycle address-capture event |
| wr_commit | output | 1 | Single-cycle qualified write event |
| halt_pulse | output | 1 | Single-cycle halt/reset for the command engine |
| out_hiz | output | 1 | Data outputs must be high impedance |
| rd_en | output | 1 | Reads permitted |

## Verification
The assertions take three things for granted: every host input holds each level for at least one full clock, so the synchronizers see it; `pwr_ok` and `rpin_n` reach a defined level before `arst_n` is released; and the duration parameters give cycle counts of at least one. The stimulus changes inputs only on the falling clock edge, holds every level for whole cycles, and leaves a quiet interval of more than twelve cycles after each strobe. That interval lets every pulse drain out of the synchronizers before the pulse counts are compared.

// File: rtl/wq_pkg.sv
package wq_pkg;

    typedef enum logic [2:0] {
        M_OFF,
        M_ACTIVE,
        M_QUAL,
        M_HALT,
        M_RECOV
    } mode_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_COUNT,
        W_ARMED,
        W_BLOCKED
    } wstate_e;

    function automatic int ns_to_cyc(input longint t_ps, input longint clk_ps);
        longint c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/wq_sync.sv
module wq_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic stage1, stage2;
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) begin
                    stage1 <= RST_VAL[i];
                    stage2 <= RST_VAL[i];
                end else begin
                    stage1 <= d_async[i];
                    stage2 <= stage1;
                end
            end
            assign q_sync[i] = stage2;
        end
    endgenerate
endmodule

// File: rtl/wq_lockout.sv
module wq_lockout #(
    parameter int LOCKOUT_CYC = 16
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pwr_s,
    output logic done
);
    localparam int            CW   = $clog2(LOCKOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(LOCKOUT_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)          cnt <= '0;
        else if (!pwr_s)      cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = pwr_s && (cnt == LAST);
endmodule

// File: rtl/wq_mode_fsm.sv
module wq_mode_fsm
    import wq_pkg::*;
#(
    parameter int RST_MIN_CYC = 8,
    parameter int RECOV_CYC   = 6
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pwr_s,
    input  logic rpin_s,
    output logic halt_pulse,
    output logic out_hiz,
    output logic rd_en,
    output logic wr_ok
);
    localparam int            MAXC      = (RST_MIN_CYC > RECOV_CYC) ? RST_MIN_CYC : RECOV_CYC;
    localparam int            CW        = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RST_LAST  = CW'(RST_MIN_CYC - 1);
    localparam logic [CW-1:0] RCV_LAST  = CW'(RECOV_CYC - 1);

    mode_e         st, nx;
    logic [CW-1:0] cnt, cnt_nx;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st  <= M_OFF;
            cnt <= '0;
        end else begin
            st  <= nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        nx     = st;
        cnt_nx = cnt;
        if (!pwr_s) begin
            nx     = M_OFF;
            cnt_nx = '0;
        end else begin
            unique case (st)
                M_OFF: begin
                    nx     = rpin_s ? M_ACTIVE : M_HALT;
                    cnt_nx = '0;
                end
                M_ACTIVE: begin
                    if (!rpin_s) begin
                        if (RST_MIN_CYC <= 1) begin
                            nx = M_HALT;
                            cnt_nx = '0;
                        end else begin
                            nx = M_QUAL;
                            cnt_nx = CW'(1);
                        end
                    end
                end
                M_QUAL: begin
                    if (rpin_s) begin
                        nx     = M_ACTIVE;
                        cnt_nx = '0;
                    end else if (cnt >= RST_LAST) begin
                        nx     = M_HALT;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                M_HALT: begin
                    if (rpin_s) begin
                        nx     = (RECOV_CYC <= 0) ? M_ACTIVE : M_RECOV;
                        cnt_nx = '0;
                    end
                end
                M_RECOV: begin
                    if (!rpin_s) begin
                        nx     = M_HALT;
                        cnt_nx = '0;
                    end else if (cnt >= RCV_LAST) begin
                        nx     = M_ACTIVE;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            halt_pulse <= 1'b0;
            out_hiz    <= 1'b1;
            rd_en      <= 1'b0;
            wr_ok      <= 1'b0;
        end else begin
            halt_pulse <= ((nx == M_HALT) && (st != M_HALT) && (st != M_RECOV)) ||
                          ((nx == M_OFF) && (st != M_OFF));
            out_hiz    <= (nx == M_OFF) || (nx == M_HALT) || (nx == M_RECOV);
            rd_en      <= (nx == M_ACTIVE) || (nx == M_QUAL);
            wr_ok      <= (nx == M_ACTIVE);
        end
    end
endmodule

// File: rtl/wq_we_fsm.sv
module wq_we_fsm
    import wq_pkg::*;
#(
    parameter int MIN_CYC = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic ce_s,
    input  logic oe_s,
    input  logic we_s,
    input  logic allow,
    output logic wr_start,
    output logic wr_commit
);
    localparam int            CW   = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

    wstate_e       st, nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic          go, start_nx, commit_nx;

    assign go = !ce_s && oe_s && allow;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st  <= W_IDLE;
            cnt <= '0;
        end else begin
            st  <= nx;
            cnt <= cnt_nx;
        end
    end

    always_comb begin
        nx        = st;
        cnt_nx    = cnt;
        start_nx  = 1'b0;
        commit_nx = 1'b0;
        unique case (st)
            W_IDLE: begin
                if (!we_s) begin
                    if (go) begin
                        start_nx = 1'b1;
                        cnt_nx   = CW'(1);
                        nx       = (MIN_CYC <= 1) ? W_ARMED : W_COUNT;
                    end else begin
                        nx = W_BLOCKED;
                    end
                end
            end
            W_COUNT: begin
                if (!go)                nx = W_BLOCKED;
                else if (we_s)          nx = W_IDLE;
                else if (cnt >= LAST)   nx = W_ARMED;
                else                    cnt_nx = cnt + 1'b1;
            end
            W_ARMED: begin
                if (!go) begin
                    nx = W_BLOCKED;
                end else if (we_s) begin
                    nx        = W_IDLE;
                    commit_nx = 1'b1;
                end
            end
            W_BLOCKED: begin
                if (we_s) nx = W_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            wr_start  <= 1'b0;
            wr_commit <= 1'b0;
        end else begin
            wr_start  <= start_nx;
            wr_commit <= commit_nx;
        end
    end
endmodule

// File: rtl/wr_qualifier.sv
module wr_qualifier
    import wq_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 2500,
    parameter int MIN_WE_PS     = 10000,
    parameter int LOCKOUT_NS    = 10000000,
    parameter int RST_MIN_NS    = 500,
    parameter int RECOV_NS      = 50
) (
    input  logic clk,
    input  logic arst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic rpin_n,
    input  logic pwr_ok,
    output logic wr_start,
    output logic wr_commit,
    output logic halt_pulse,
    output logic out_hiz,
    output logic rd_en
);
    localparam int MIN_WE_CYC  = ns_to_cyc(longint'(MIN_WE_PS), longint'(CLK_PERIOD_PS));
    localparam int LOCKOUT_CYC = ns_to_cyc(longint'(LOCKOUT_NS) * 1000, longint'(CLK_PERIOD_PS));
    localparam int RST_MIN_CYC = ns_to_cyc(longint'(RST_MIN_NS) * 1000, longint'(CLK_PERIOD_PS));
    localparam int RECOV_CYC   = ns_to_cyc(longint'(RECOV_NS) * 1000, longint'(CLK_PERIOD_PS));

    logic [4:0] raw_in, syn_in;
    logic       ce_s, oe_s, we_s, rpin_s, pwr_s;
    logic       lock_done, mode_wr_ok;

    assign raw_in = {pwr_ok, rpin_n, we_n, oe_n, ce_n};
    assign {pwr_s, rpin_s, we_s, oe_s, ce_s} = syn_in;

    wq_sync #(.W(5), .RST_VAL(5'b01111)) u_sync (
        .clk     (clk),
        .arst_n  (arst_n),
        .d_async (raw_in),
        .q_sync  (syn_in)
    );

    wq_lockout #(.LOCKOUT_CYC(LOCKOUT_CYC)) u_lock (
        .clk    (clk),
        .arst_n (arst_n),
        .pwr_s  (pwr_s),
        .done   (lock_done)
    );

    wq_mode_fsm #(.RST_MIN_CYC(RST_MIN_CYC), .RECOV_CYC(RECOV_CYC)) u_mode (
        .clk        (clk),
        .arst_n     (arst_n),
        .pwr_s      (pwr_s),
        .rpin_s     (rpin_s),
        .halt_pulse (halt_pulse),
        .out_hiz    (out_hiz),
        .rd_en      (rd_en),
        .wr_ok      (mode_wr_ok)
    );

    wq_we_fsm #(.MIN_CYC(MIN_WE_CYC)) u_we (
        .clk       (clk),
        .arst_n    (arst_n),
        .ce_s      (ce_s),
        .oe_s      (oe_s),
        .we_s      (we_s),
        .allow     (mode_wr_ok && lock_done),
        .wr_start  (wr_start),
        .wr_commit (wr_commit)
    );
endmodule

// File: rtl/wq_checker.sv
module wq_checker (
    input logic clk,
    input logic arst_n,
    input logic wr_start,
    input logic wr_commit,
    input logic halt_pulse,
    input logic out_hiz,
    input logic rd_en,
    input logic lock_done
);
    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
        wr_start |=> !wr_start);

    // R5
    commit_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
        wr_commit |=> !wr_commit);

    // R8
    halt_single_chk: assert property (@(posedge clk) disable iff (!arst_n)
        halt_pulse |=> !halt_pulse);

    // R8
    halt_hiz_chk: assert property (@(posedge clk) disable iff (!arst_n)
        halt_pulse |-> out_hiz);

    // R2
    hiz_read_excl_chk: assert property (@(posedge clk) disable iff (!arst_n)
        out_hiz |-> !rd_en);

    // R3
    commit_after_lock_chk: assert property (@(posedge clk) disable iff (!arst_n)
        wr_commit |-> $past(lock_done));

    // R1
    always_comb begin
        if (!arst_n) begin
            reset_idle_chk: assert (!wr_start && !wr_commit && !halt_pulse);
        end
    end
endmodule

bind wr_qualifier wq_checker u_chk (
    .clk        (clk),
    .arst_n     (arst_n),
    .wr_start   (wr_start),
    .wr_commit  (wr_commit),
    .halt_pulse (halt_pulse),
    .out_hiz    (out_hiz),
    .rd_en      (rd_en),
    .lock_done  (lock_done)
);

// File: tb/sim_wr_qualifier.sv
`timescale 1ns/1ps
module sim_wr_qualifier;
    localparam int RECOV = 6;

    logic clk = 1'b0;
    logic arst_n, ce_n, oe_n, we_n, rpin_n, pwr_ok;
    logic wr_start, wr_commit, halt_pulse, out_hiz, rd_en;

    int n_chk = 0, n_bad = 0;
    int n_start = 0, n_commit = 0, n_halt = 0, n_hiz = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    wr_qualifier #(
        .CLK_PERIOD_PS (10000),
        .MIN_WE_PS     (40000),
        .LOCKOUT_NS    (500),
        .RST_MIN_NS    (80),
        .RECOV_NS      (60)
    ) u0 (
        .clk(clk), .arst_n(arst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rpin_n(rpin_n), .pwr_ok(pwr_ok), .wr_start(wr_start), .wr_commit(wr_commit),
        .halt_pulse(halt_pulse), .out_hiz(out_hiz), .rd_en(rd_en)
    );

    always @(negedge clk) begin
        if (wr_start)   n_start++;
        if (wr_commit)  n_commit++;
        if (halt_pulse) n_halt++;
        if (out_hiz)    n_hiz++;
    end

    // {ce_n, oe_n, low length[7:0], expected start, expected commit}
    localparam int NV = 8;
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 1'b1, 8'd4,  1'b1, 1'b1},
        {1'b0, 1'b1, 8'd3,  1'b1, 1'b0},
        {1'b0, 1'b1, 8'd1,  1'b1, 1'b0},
        {1'b0, 1'b1, 8'd10, 1'b1, 1'b1},
        {1'b1, 1'b1, 8'd6,  1'b0, 1'b0},
        {1'b0, 1'b0, 8'd6,  1'b0, 1'b0},
        {1'b1, 1'b0, 8'd6,  1'b0, 1'b0},
        {1'b0, 1'b1, 8'd5,  1'b1, 1'b1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic strobe(input logic ce, input logic oe, input int len,
                          output int ds, output int dc);
        int s0, c0;
        s0 = n_start; c0 = n_commit;
        @(negedge clk); ce_n = ce; oe_n = oe;
        @(negedge clk); we_n = 1'b0;
        repeat (len) @(negedge clk);
        we_n = 1'b1;
        repeat (14) @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b1;
        ds = n_start - s0; dc = n_commit - c0;
    endtask

    initial begin
        int ds, dc, h0, z0, k;
        arst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; rpin_n = 1'b1; pwr_ok = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 start", wr_start, 0);
        check("R1 commit", wr_commit, 0);
        check("R1 halt", halt_pulse, 0);
        check("R1 hiz", out_hiz, 1);
        check("R1 rd_en", rd_en, 0);
        arst_n = 1'b1;
        repeat (8) @(negedge clk);
        // R2 supply low
        check("R2 rd_en", rd_en, 0);
        check("R2 hiz", out_hiz, 1);
        strobe(1'b0, 1'b1, 6, ds, dc);
        check("R2 start", ds, 0);
        check("R2 commit", dc, 0);

        // R3 lockout after supply up
        @(negedge clk); pwr_ok = 1'b1;
        repeat (6) @(negedge clk);
        check("R3 rd_en", rd_en, 1);
        check("R3 hiz", out_hiz, 0);
        strobe(1'b0, 1'b1, 6, ds, dc);
        check("R3 start in lockout", ds, 0);
        check("R3 commit in lockout", dc, 0);
        repeat (45) @(negedge clk);

        // R4 R5 R6 R7 vector table
        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i][11], VEC[i][10], int'(VEC[i][9:2]), ds, dc);
            check($sformatf("R4/R7 vec%0d start", i), ds, int'(VEC[i][1]));
            check($sformatf("R5/R6 vec%0d commit", i), dc, int'(VEC[i][0]));
        end

        // R7 abort: chip-enable rises while the strobe is low
        h0 = n_start; k = n_commit;
        @(negedge clk); we_n = 1'b0;
        repeat (6) @(negedge clk); ce_n = 1'b1;
        repeat (3) @(negedge clk); we_n = 1'b1;
        repeat (14) @(negedge clk); ce_n = 1'b0;
        check("R7 abort start", n_start - h0, 1);
        check("R7 abort commit", n_commit - k, 0);

        // R7 strobe already low when inhibit clears
        h0 = n_start; k = n_commit;
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk); we_n = 1'b0;
        repeat (4) @(negedge clk); ce_n = 1'b0;
        repeat (8) @(negedge clk); we_n = 1'b1;
        repeat (14) @(negedge clk);
        check("R7 late enable start", n_start - h0, 0);
        check("R7 late enable commit", n_commit - k, 0);

        // R9 short reset pulse
        h0 = n_halt; z0 = n_hiz;
        @(negedge clk); rpin_n = 1'b0;
        repeat (7) @(negedge clk); rpin_n = 1'b1;
        repeat (10) @(negedge clk);
        check("R9 halt", n_halt - h0, 0);
        check("R9 hiz cycles", n_hiz - z0, 0);
        strobe(1'b0, 1'b1, 5, ds, dc);
        check("R9 commit after short reset", dc, 1);

        // R8 long reset pulse, write attempted while halted
        h0 = n_halt;
        @(negedge clk); rpin_n = 1'b0;
        repeat (12) @(negedge clk);
        check("R8 hiz", out_hiz, 1);
        check("R8 rd_en", rd_en, 0);
        strobe(1'b0, 1'b1, 5, ds, dc);
        check("R8 start while halted", ds, 0);
        check("R8 commit while halted", dc, 0);
        check("R8 halt count", n_halt - h0, 1);

        // R10 recovery interval
        rpin_n = 1'b1;
        k = 0;
        while (!rd_en && k < 40) begin @(negedge clk); k++; end
        check("R10 recovery min", (k >= RECOV) ? 1 : 0, 1);
        check("R10 recovery max", (k <= RECOV + 4) ? 1 : 0, 1);
        strobe(1'b0, 1'b1, 5, ds, dc);
        check("R10 commit after recovery", dc, 1);

        // R11 supply loss and renewed lockout
        h0 = n_halt;
        @(negedge clk); pwr_ok = 1'b0;
        repeat (6) @(negedge clk);
        check("R11 halt on supply loss", n_halt - h0, 1);
        check("R2 hiz after loss", out_hiz, 1);
        pwr_ok = 1'b1;
        repeat (6) @(negedge clk);
        strobe(1'b0, 1'b1, 5, ds, dc);
        check("R11 commit in new lockout", dc, 0);
        repeat (50) @(negedge clk);
        strobe(1'b0, 1'b1, 5, ds, dc);
        check("R11 commit after new lockout", dc, 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule